// File: doc/BRIEF.md
# EDO Page-Mode DRAM Access Sequencer

This block sits between a simple host request port and an extended-data-out DRAM whose four data bits each have their own column strobe. Every accepted request carries a combined row/column address, four bits of write data and a four-bit lane mask. The sequencer drives the multiplexed address pins and the row strobe, the four column strobes, write-enable and output-enable. It captures read data at the end of the column strobe and hands it back with a one-cycle valid pulse.

After an access the row is left open. A later request to the same row costs only a column cycle. A request to another row first closes the open row for the precharge time and then opens the new one. A row-age counter closes the row before the longest legal row-strobe low time is reached, so an idle or busy open row never overstays. Each write chooses between an early write, where write-enable is already low when the strobes fall, and an output-enable-controlled write, where write-enable falls one cycle later. Every timing value is a parameter counted in clock cycles.

Top module: `edo_page_seq`

## Requirements
- R1: While reset is held, dram_ras_n, dram_we_n and dram_oe_n are 1, dram_cas_n is 4'b1111, dram_dq_oe and rd_valid are 0, and req_ready is 1.
- R2: The upper ROW_W bits of req_addr are the row and the lower COL_W bits are the column. The row, zero-extended, is on dram_addr in the cycle dram_ras_n falls. The column, zero-extended, is on dram_addr in every cycle that any dram_cas_n bit is low.
- R3: Lane i owns data bit i and dram_cas_n[i]. A write drives dram_cas_n[i] low only where req_mask[i] is 1, so masked-off bits of the DRAM keep their value. A read drives all four strobes low.
- R4: With req_early = 1, a write holds dram_we_n low in every cycle its strobes are low. During any write dram_oe_n stays 1, and while dram_we_n is low dram_dq_oe is 1 and dram_dq_o equals the request's write data.
- R5: With req_early = 0, a write keeps dram_we_n high in its first strobe-low cycle and drives it low in the remaining strobe-low cycles.
- R6: A request to the open row, accepted while there is row-age room, issues only a column cycle with no new fall of dram_ras_n. Its rd_valid arrives T_CAS cycles after acceptance.
- R7: A request to a different row waits until dram_ras_n has been high for at least T_RP cycles. The column strobes fall exactly T_RCD cycles after dram_ras_n falls, and never while dram_ras_n is high. rd_valid arrives T_RCD + T_CAS cycles after acceptance.
- R8: dram_ras_n is never low for more than ROW_MAX consecutive cycles. An open row closes by itself when it has no more room, whether the port is idle or busy with hits.
- R9: Each low period of dram_ras_n lasts at least T_RAS_MIN cycles.
- R10: rd_data is dram_dq_i sampled in the last strobe-low cycle of a read. It is returned with a one-cycle rd_valid pulse, and reads complete in request order.
- R11: Each column strobe low period lasts exactly T_CAS cycles. Between two column cycles in one row the strobes stay high for at least T_CP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_early | input | 1 | 1 for early write, 0 for output-enable-controlled write |
| req_addr | input | ROW_W+COL_W | Row in upper bits, column in lower bits |
| req_wdata | input | LANES | Write data, one bit per lane |
| req_mask | input | LANES | Write lane enable |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | LANES | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | LANES | Column strobes, one per lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed address pins |
| dram_dq_o | output | LANES | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | LANES | Data from the DRAM |

## Verification
A read that hits the open row must return rd_valid exactly T_CAS cycles after its acceptance edge. A read that had to open a row must return it exactly T_RCD + T_CAS cycles after. The bench counts the rows opened between acceptance and the pulse to decide which figure applies. The column strobes must fall exactly T_RCD cycles after the row strobe, and the bench measures that gap at every row opening. Outputs are sampled on the falling clock edge, half a cycle after the register that drives them, and inputs are changed only there. The bench sweeps every address of a small 3+3-bit geometry with full and partial lane masks and both write styles. It then runs a long hit burst that must reopen its row exactly once, and an alternating-row pattern that must open a row on every access.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // row closed
        ST_RCD  = 3'd1,   // row strobe low, waiting before column strobe
        ST_COL  = 3'd2,   // column strobe(s) low
        ST_CPRE = 3'd3,   // column precharge inside the open row
        ST_OPEN = 3'd4,   // row open, waiting for work
        ST_PRE  = 3'd5    // row precharge
    } seq_state_e;

endpackage

// File: rtl/edo_addr_split.sv
module edo_addr_split #(
    parameter int ROW_W = 12,
    parameter int COL_W = 10,
    parameter int PIN_W = 12
) (
    input  logic [ROW_W+COL_W-1:0] host_addr,
    input  logic [ROW_W-1:0]       open_row,
    input  logic [ROW_W-1:0]       cur_row,
    input  logic [COL_W-1:0]       cur_col,
    output logic [ROW_W-1:0]       host_row,
    output logic [COL_W-1:0]       host_col,
    output logic                   same_row,
    output logic [PIN_W-1:0]       row_pins,
    output logic [PIN_W-1:0]       col_pins
);
    assign host_row = host_addr[ROW_W+COL_W-1:COL_W];
    assign host_col = host_addr[COL_W-1:0];
    assign same_row = (host_row == open_row);

    generate
        if (PIN_W > ROW_W) begin : g_row_pad
            assign row_pins = {{(PIN_W-ROW_W){1'b0}}, cur_row};
        end else begin : g_row_fit
            assign row_pins = cur_row;
        end
        if (PIN_W > COL_W) begin : g_col_pad
            assign col_pins = {{(PIN_W-COL_W){1'b0}}, cur_col};
        end else begin : g_col_fit
            assign col_pins = cur_col;
        end
    endgenerate
endmodule

// File: rtl/edo_row_budget.sv
module edo_row_budget #(
    parameter int ROW_MAX   = 10000,
    parameter int T_CAS     = 2,
    parameter int T_CP      = 1,
    parameter int T_RAS_MIN = 3,
    parameter int AGE_W     = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic row_low,
    output logic room,
    output logic ras_ok
);
    // A hit taken at age a leaves the row low for a + T_CAS + T_CP + 2 cycles at most.
    localparam int              ROOM_LIM = ROW_MAX - T_CAS - T_CP - 2;
    localparam logic [AGE_W-1:0] ROOM_V  = AGE_W'(ROOM_LIM);
    localparam logic [AGE_W-1:0] RAS_V   = AGE_W'(T_RAS_MIN - 1);
    localparam logic [AGE_W-1:0] AGE_TOP = '1;

    logic [AGE_W-1:0] age_d, age_q;

    always_comb begin
        age_d = '0;
        if (row_low) begin
            age_d = (age_q == AGE_TOP) ? age_q : age_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    assign room   = (age_q <= ROOM_V);
    assign ras_ok = (age_q >= RAS_V);

    // R8: the age restarts whenever the row is closed
    p_age_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !row_low |=> (age_q == '0));
endmodule

// File: rtl/edo_page_seq.sv
module edo_page_seq
    import edo_seq_pkg::*;
#(
    parameter int ROW_W     = 12,
    parameter int COL_W     = 10,
    parameter int LANES     = 4,
    parameter int T_RCD     = 1,
    parameter int T_CAS     = 2,
    parameter int T_CP      = 1,
    parameter int T_RP      = 2,
    parameter int T_RAS_MIN = 3,
    parameter int ROW_MAX   = 10000
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       req_valid,
    output logic                                       req_ready,
    input  logic                                       req_write,
    input  logic                                       req_early,
    input  logic [ROW_W+COL_W-1:0]                     req_addr,
    input  logic [LANES-1:0]                           req_wdata,
    input  logic [LANES-1:0]                           req_mask,
    output logic                                       rd_valid,
    output logic [LANES-1:0]                           rd_data,
    output logic                                       dram_ras_n,
    output logic [LANES-1:0]                           dram_cas_n,
    output logic                                       dram_we_n,
    output logic                                       dram_oe_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic [LANES-1:0]                           dram_dq_o,
    output logic                                       dram_dq_oe,
    input  logic [LANES-1:0]                           dram_dq_i
);
    localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int T_A    = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int T_B    = (T_CP > T_RP) ? T_CP : T_RP;
    localparam int T_MAX  = (T_A > T_B) ? T_A : T_B;
    localparam int TMR_W  = $clog2(T_MAX + 1);
    localparam int AGE_W  = $clog2(ROW_MAX + 2);

    localparam logic [TMR_W-1:0] RCD_L = TMR_W'(T_RCD - 1);
    localparam logic [TMR_W-1:0] CAS_L = TMR_W'(T_CAS - 1);
    localparam logic [TMR_W-1:0] CP_L  = TMR_W'(T_CP - 1);
    localparam logic [TMR_W-1:0] RP_L  = TMR_W'(T_RP - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [TMR_W-1:0]   tmr;
        logic               wr;
        logic               early;
        logic [ROW_W-1:0]   row;
        logic [COL_W-1:0]   col;
        logic [LANES-1:0]   wdata;
        logic [LANES-1:0]   mask;
        logic               rd_valid;
        logic [LANES-1:0]   rd_data;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [ROW_W-1:0] host_row;
    logic [COL_W-1:0] host_col;
    logic             same_row;
    logic [PIN_W-1:0] row_pins, col_pins;
    logic             row_low, room, ras_ok, accept;

    edo_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)) u_split (
        .host_addr (req_addr),
        .open_row  (seq_q.row),
        .cur_row   (seq_q.row),
        .cur_col   (seq_q.col),
        .host_row  (host_row),
        .host_col  (host_col),
        .same_row  (same_row),
        .row_pins  (row_pins),
        .col_pins  (col_pins)
    );

    assign row_low = (seq_q.st == ST_RCD) || (seq_q.st == ST_COL) ||
                     (seq_q.st == ST_CPRE) || (seq_q.st == ST_OPEN);

    edo_row_budget #(.ROW_MAX(ROW_MAX), .T_CAS(T_CAS), .T_CP(T_CP),
                     .T_RAS_MIN(T_RAS_MIN), .AGE_W(AGE_W)) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .row_low (row_low),
        .room    (room),
        .ras_ok  (ras_ok)
    );

    assign req_ready = (seq_q.st == ST_IDLE) ||
                       ((seq_q.st == ST_OPEN) && same_row && room);
    assign accept    = req_valid && req_ready;

    always_comb begin
        seq_d          = seq_q;
        seq_d.rd_valid = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (accept) begin
                    seq_d.st    = ST_RCD;
                    seq_d.tmr   = RCD_L;
                    seq_d.row   = host_row;
                    seq_d.col   = host_col;
                    seq_d.wr    = req_write;
                    seq_d.early = req_early;
                    seq_d.wdata = req_wdata;
                    seq_d.mask  = req_mask;
                end
            end
            ST_RCD: begin
                if (seq_q.tmr == '0) begin
                    seq_d.st  = ST_COL;
                    seq_d.tmr = CAS_L;
                end else begin
                    seq_d.tmr = seq_q.tmr - 1'b1;
                end
            end
            ST_COL: begin
                if (seq_q.tmr == '0) begin
                    if (!seq_q.wr) begin
                        seq_d.rd_valid = 1'b1;
                        seq_d.rd_data  = dram_dq_i;
                    end
                    seq_d.st  = ST_CPRE;
                    seq_d.tmr = CP_L;
                end else begin
                    seq_d.tmr = seq_q.tmr - 1'b1;
                end
            end
            ST_CPRE: begin
                if (seq_q.tmr == '0) seq_d.st  = ST_OPEN;
                else                 seq_d.tmr = seq_q.tmr - 1'b1;
            end
            ST_OPEN: begin
                if (accept) begin
                    seq_d.st    = ST_COL;
                    seq_d.tmr   = CAS_L;
                    seq_d.col   = host_col;
                    seq_d.wr    = req_write;
                    seq_d.early = req_early;
                    seq_d.wdata = req_wdata;
                    seq_d.mask  = req_mask;
                end else if ((req_valid || !room) && ras_ok) begin
                    seq_d.st  = ST_PRE;
                    seq_d.tmr = RP_L;
                end
            end
            ST_PRE: begin
                if (seq_q.tmr == '0) seq_d.st  = ST_IDLE;
                else                 seq_d.tmr = seq_q.tmr - 1'b1;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    logic in_col;
    always_comb begin
        in_col     = (seq_q.st == ST_COL);
        dram_ras_n = !row_low;
        dram_cas_n = in_col ? (seq_q.wr ? ~seq_q.mask : '0) : '1;
        dram_we_n  = !(in_col && seq_q.wr && (seq_q.early || (seq_q.tmr != CAS_L)));
        dram_oe_n  = !(in_col && !seq_q.wr);
        dram_dq_oe = !dram_we_n;
        dram_dq_o  = seq_q.wdata;
        dram_addr  = ((seq_q.st == ST_COL) || (seq_q.st == ST_CPRE) ||
                      (seq_q.st == ST_OPEN)) ? col_pins : row_pins;
        rd_valid   = seq_q.rd_valid;
        rd_data    = seq_q.rd_data;
    end

    // Strobe run counters used only by the checks below.
    localparam logic [AGE_W-1:0] RUN_TOP = '1;
    localparam logic [AGE_W-1:0] LIM_V   = AGE_W'(ROW_MAX);
    localparam logic [AGE_W-1:0] RP_V    = AGE_W'(T_RP);
    localparam logic [AGE_W-1:0] RMIN_V  = AGE_W'(T_RAS_MIN);
    logic [AGE_W-1:0] low_run_q, hi_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q <= '0;
            hi_run_q  <= RP_V;
        end else begin
            low_run_q <= dram_ras_n ? '0 : ((low_run_q == RUN_TOP) ? low_run_q : low_run_q + 1'b1);
            hi_run_q  <= !dram_ras_n ? '0 : ((hi_run_q == RUN_TOP) ? hi_run_q : hi_run_q + 1'b1);
        end
    end

    p_row_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> (low_run_q < LIM_V));
    p_ras_precharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (hi_run_q >= RP_V));
    p_cas_needs_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_cas_n != '1) |-> !dram_ras_n);
    p_ras_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (low_run_q >= RMIN_V));
    p_write_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> (dram_oe_n && dram_dq_oe));
    p_we_in_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> (dram_cas_n != '1));
    p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: tb/edo_page_seq_test.sv
module edo_page_seq_test;
    localparam int ROW_W = 3, COL_W = 3, LANES = 4;
    localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 2, T_RAS_MIN = 4, ROW_MAX = 24;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_ready, req_write = 0, req_early = 0;
    logic [5:0] req_addr = '0;
    logic [3:0] req_wdata = '0, req_mask = '0;
    logic rd_valid; logic [3:0] rd_data;
    logic ras_n, we_n, oe_n, dq_oe;
    logic [3:0] cas_n, dq_o, dq_i;
    logic [2:0] pins;

    edo_page_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .LANES(LANES), .T_RCD(T_RCD), .T_CAS(T_CAS),
                   .T_CP(T_CP), .T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN), .ROW_MAX(ROW_MAX)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_early(req_early), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
        .dram_addr(pins), .dram_dq_o(dq_o), .dram_dq_oe(dq_oe), .dram_dq_i(dq_i));

    always #10 clk = ~clk;

    int tests = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) if (cyc == 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected 0", cyc);
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    // Small DRAM model, four single-bit lanes.
    logic [3:0] mem [0:63];
    logic [2:0] row_lat = '0;
    always_comb
        for (int i = 0; i < 4; i++)
            dq_i[i] = (!cas_n[i] && !oe_n) ? mem[{row_lat, pins}][i] : 1'b0;

    // Accepted request, captured at the acceptance edge.
    logic [2:0] cur_row = '0, cur_col = '0;
    logic [3:0] cur_mask = '0, cur_data = '0;
    logic cur_wr = 0, cur_early = 0;
    always @(posedge clk) if (rst_n && req_valid && req_ready) begin
        cur_row <= req_addr[5:3]; cur_col <= req_addr[2:0];
        cur_mask <= req_mask; cur_data <= req_wdata;
        cur_wr <= req_write; cur_early <= req_early;
    end

    // Protocol monitor, sampled at the falling edge.
    int e_r2 = 0, e_r3 = 0, e_r4 = 0, e_r5 = 0, e_r7 = 0, e_r8 = 0, e_r9 = 0, e_r11 = 0;
    int ras_falls = 0, fall_cyc = 0, lo_run = 0, hi_run = 0, cas_lo = 0, cas_hi = 0;
    bit prev_ras = 1, pend = 0, seen_low = 0;
    logic [3:0] prev_cas = 4'hF;
    always @(negedge clk) if (rst_n) begin
        if (prev_ras && !ras_n) begin
            ras_falls++; fall_cyc = cyc; pend = 1; lo_run = 0;
            row_lat = pins;
            if (pins !== cur_row) e_r2++;
            if (seen_low && hi_run < T_RP) e_r7++;
        end
        if (!prev_ras && ras_n) begin
            if (lo_run < T_RAS_MIN) e_r9++;
            hi_run = 0; seen_low = 1;
        end
        if (!ras_n) begin lo_run++; if (lo_run > ROW_MAX) e_r8++; end
        else hi_run++;
        if (cas_n != 4'hF) begin
            if (prev_cas == 4'hF) begin
                if (pend) begin if (cyc - fall_cyc != T_RCD) e_r7++; pend = 0; end
                else if (cas_hi < T_CP) e_r11++;
                cas_lo = 0;
            end
            cas_lo++;
            if (ras_n) e_r7++;
            if (pins !== cur_col) e_r2++;
            if (cas_n !== (cur_wr ? ~cur_mask : 4'h0)) e_r3++;
            if (cur_wr) begin
                if (!oe_n) e_r4++;
                if (!we_n && (!dq_oe || dq_o !== cur_data)) e_r4++;
                if (cur_early) begin if (we_n) e_r4++; end
                else if (prev_cas == 4'hF) begin if (!we_n) e_r5++; end
                else if (we_n) e_r5++;
                for (int i = 0; i < 4; i++)
                    if (!cas_n[i] && !we_n && dq_oe) mem[{row_lat, pins}][i] = dq_o[i];
            end else if (!we_n || oe_n) e_r3++;
        end else begin
            if (prev_cas != 4'hF && cas_lo != T_CAS) e_r11++;
            if (prev_cas != 4'hF) cas_hi = 0;
            cas_hi++;
            if (!we_n) e_r4++;
        end
        prev_ras = ras_n; prev_cas = cas_n;
    end

    logic [3:0] exp_mem [0:63];
    int acc_cyc = 0, falls_pre = 0;

    function automatic logic [3:0] patt(input int a);
        return 4'((a * 7 + 3) & 15);
    endfunction

    task automatic issue(input bit wr, input bit early, input int a, input logic [3:0] d, input logic [3:0] m);
        req_write = wr; req_early = early; req_addr = 6'(a);
        req_wdata = d; req_mask = m; req_valid = 1;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        falls_pre = ras_falls;
        @(posedge clk); @(negedge clk);
        acc_cyc = cyc; req_valid = 0;
        if (wr) exp_mem[a] = (exp_mem[a] & ~m) | (d & m);
    endtask

    task automatic rd(input int a);
        int lat, nf;
        issue(0, 0, a, 4'h0, 4'hF);
        while (!rd_valid) @(negedge clk);
        #1;
        lat = cyc - acc_cyc; nf = ras_falls - falls_pre;
        chk(rd_data === exp_mem[a], "R10 R3 read data", rd_data, exp_mem[a]);
        if (nf == 0) chk(lat == T_CAS, "R6 hit latency", lat, T_CAS);
        else         chk(nf == 1 && lat == T_RCD + T_CAS, "R7 open latency", lat, T_RCD + T_CAS);
    endtask

    initial begin
        int f0;
        for (int i = 0; i < 64; i++) begin mem[i] = '0; exp_mem[i] = '0; end
        repeat (3) @(negedge clk);
        chk(ras_n && we_n && oe_n && cas_n == 4'hF, "R1 strobes idle", {ras_n, cas_n, we_n, oe_n}, 7'h7F);
        chk(!dq_oe && !rd_valid && req_ready, "R1 port idle", {dq_oe, rd_valid, req_ready}, 1);
        rst_n = 1;
        @(negedge clk);
        for (int a = 0; a < 64; a++) issue(1, a[0], a, patt(a), 4'hF);
        for (int a = 0; a < 64; a++) rd(a);
        for (int a = 0; a < 64; a++) issue(1, a[1], a, ~patt(a + 5), 4'((a % 15) + 1));
        for (int a = 63; a >= 0; a--) rd(a);
        repeat (ROW_MAX + 10) @(negedge clk);
        chk(ras_n == 1'b1, "R8 idle row closes", ras_n, 1);
        f0 = ras_falls;
        for (int c = 0; c < 6; c++) rd(40 + c);
        chk(ras_falls - f0 == 2, "R8 R6 burst row openings", ras_falls - f0, 2);
        f0 = ras_falls;
        for (int k = 0; k < 4; k++) rd(((k % 2) ? 16 : 8) + 3);
        chk(ras_falls - f0 == 4, "R7 alternating rows", ras_falls - f0, 4);
        repeat (4) @(negedge clk);
        chk(e_r2 == 0, "R2 address phases", e_r2, 0);
        chk(e_r3 == 0, "R3 lane strobes", e_r3, 0);
        chk(e_r4 == 0, "R4 early write", e_r4, 0);
        chk(e_r5 == 0, "R5 oe-controlled write", e_r5, 0);
        chk(e_r7 == 0, "R7 precharge and rcd", e_r7, 0);
        chk(e_r8 == 0, "R8 row low limit", e_r8, 0);
        chk(e_r9 == 0, "R9 row low minimum", e_r9, 0);
        chk(e_r11 == 0, "R11 column strobe timing", e_r11, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule